// File: doc/BRIEF.md
# Bitmap Layer Pixel Fetch Addresser

This block sits between the display beam counters and the video SRAM of a 256-colour bitmap overlay layer. For every beam position it folds in the scroll offsets, turns the scrolled coordinate into a physical byte address (a bank number plus a 14-bit offset within a 16 KiB bank) and, once the memory has answered, turns the returned byte into an 8-bit palette index. It has three geometries: 256x192 at one byte per pixel stored row by row, 320x256 at one byte per pixel stored column by column, and 640x256 with two pixels packed per byte in the same column-ordered layout.

A beam request is registered into an address stage. The video memory is expected to present the byte for that address combinationally on `mem_data` during the same cycle. The block then registers the palette index one cycle later. The mode, first bank and palette offset are captured together with the beam coordinate, so each pixel is formed from the settings that were present when it was requested.

Top module: `bitmap_fetch`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `addr_vld` and `pix_vld` are 0. After reset, `addr_bank`, `addr_ofs` and `pix_index` are 0.
- R2: `addr_vld` equals `beam_vld` from one cycle earlier. `pix_vld` equals `addr_vld` from one cycle earlier. `pix_index` is formed from the `mem_data` value present while `addr_vld` was high.
- R3: In mode code 0 (256x192), with scrolled coordinate (X, Y), the bank is `first_bank + Y/64` and the offset is `(Y mod 64)*256 + X`.
- R4: In mode code 1 (320x256), the bank is `first_bank + X/64` and the offset is `(X mod 64)*256 + Y`.
- R5: In mode code 2 (640x256), the byte column is C = X/2. The bank is `first_bank + C/64` and the offset is `(C mod 64)*256 + Y`. An even X selects bits 7:4 of the byte and an odd X selects bits 3:0.
- R6: The scrolled coordinate is X = (`beam_x` + `scroll_x`) mod W and Y = (`beam_y` + `scroll_y`) mod H. W/H is 256/192, 320/256 or 640/256 for the mode. This holds for any scroll value within the port width.
- R7: In modes 0 and 1, with memory byte D, `pix_index[7:4]` = (D[7:4] + `pal_ofs`) mod 16 and `pix_index[3:0]` = D[3:0].
- R8: In mode 2, `pix_index[7:4]` = `pal_ofs` and `pix_index[3:0]` is the selected nibble.
- R9: The bank sum is 8 bits wide and wraps modulo 256.
- R10: Mode code 3 behaves exactly as mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beam_vld | input | 1 | A pixel is requested this cycle |
| beam_x | input | 10 | Beam column, below the mode width |
| beam_y | input | 9 | Beam line, below the mode height |
| mode | input | 2 | 0: 256x192, 1: 320x256, 2: 640x256 packed, 3: as 0 |
| first_bank | input | 8 | Bank number holding the first part of the image |
| scroll_x | input | 10 | Horizontal scroll offset |
| scroll_y | input | 9 | Vertical scroll offset |
| pal_ofs | input | 4 | Palette offset added to the upper nibble |
| addr_vld | output | 1 | Address outputs hold a request |
| addr_bank | output | 8 | Physical 16 KiB bank number |
| addr_ofs | output | 14 | Byte offset within the bank |
| mem_data | input | 8 | Byte read at the current address |
| pix_vld | output | 1 | `pix_index` holds a pixel |
| pix_index | output | 8 | Palette index of the pixel |

## Verification
The bench sweeps every column of each mode on a few lines, and every line on a few columns. This catches a design that swaps the row-major and column-major layouts, or that uses the pixel column instead of the byte column in packed mode: either one would emit offsets that land on the wrong byte or the wrong bank. Large scroll values such as 1023 and 511 go after a fold that subtracts the width only once, which would leave coordinates beyond the image. A first bank near 255 exposes a bank sum that is too wide or that saturates. A palette offset of 15 exposes a carry leaking out of the upper nibble. Packed-mode pixels at even and odd columns catch reversed nibble order.

// File: rtl/bf_pkg.sv
package bf_pkg;

    parameter int X_W       = 10;
    parameter int Y_W       = 9;
    parameter int BANK_W    = 8;
    parameter int OFS_W     = 14;
    parameter int PIX_W     = 8;
    parameter int PAL_W     = 4;
    parameter int BYTE_BITS = 8;

    localparam int SX_W      = X_W + 1;
    localparam int SY_W      = Y_W + 1;
    localparam int SPAN_BITS = OFS_W - BYTE_BITS;
    localparam int NIB_W     = PIX_W / 2;
    localparam int IDX_W     = 3;

    typedef enum logic [1:0] {
        MODE_256X192 = 2'd0,
        MODE_320X256 = 2'd1,
        MODE_640X256 = 2'd2,
        MODE_SPARE   = 2'd3
    } lay_mode_e;

    typedef struct packed {
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
    } coord_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFS_W-1:0]  ofs;
        logic              lo_nib;
        logic              packed4;
        logic [PAL_W-1:0]  pal;
    } fetch_t;

    function automatic lay_mode_e to_mode(input logic [1:0] code);
        lay_mode_e m;
        case (code)
            2'd1:    m = MODE_320X256;
            2'd2:    m = MODE_640X256;
            default: m = MODE_256X192;
        endcase
        return m;
    endfunction

    function automatic int mode_width(input int m);
        return (m == 2) ? 640 : (m == 1) ? 320 : 256;
    endfunction

    function automatic int mode_height(input int m);
        return (m == 0) ? 192 : 256;
    endfunction

endpackage

// File: rtl/bf_scroll_wrap.sv
module bf_scroll_wrap
    import bf_pkg::*;
(
    input  lay_mode_e mode,
    input  coord_t    beam,
    input  coord_t    shift,
    output coord_t    pos
);
    localparam int NUM_MODES = 3;

    logic [SX_W-1:0] xsum;
    logic [SY_W-1:0] ysum;
    logic [NUM_MODES-1:0][SX_W-1:0] xfold;
    logic [NUM_MODES-1:0][SY_W-1:0] yfold;

    assign xsum = SX_W'(beam.x) + SX_W'(shift.x);
    assign ysum = SY_W'(beam.y) + SY_W'(shift.y);

    // One constant-divisor fold per geometry; the mode picks one.
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_fold
        localparam logic [SX_W-1:0] WLIM = SX_W'(mode_width(m));
        localparam logic [SY_W-1:0] HLIM = SY_W'(mode_height(m));
        assign xfold[m] = xsum % WLIM;
        assign yfold[m] = ysum % HLIM;
    end

    always_comb begin
        case (mode)
            MODE_320X256: begin
                pos.x = xfold[1][X_W-1:0];
                pos.y = yfold[1][Y_W-1:0];
            end
            MODE_640X256: begin
                pos.x = xfold[2][X_W-1:0];
                pos.y = yfold[2][Y_W-1:0];
            end
            default: begin
                pos.x = xfold[0][X_W-1:0];
                pos.y = yfold[0][Y_W-1:0];
            end
        endcase
    end
endmodule

// File: rtl/bf_addr_map.sv
module bf_addr_map
    import bf_pkg::*;
(
    input  lay_mode_e         mode,
    input  coord_t            pos,
    input  logic [BANK_W-1:0] first_bank,
    output logic [BANK_W-1:0] bank,
    output logic [OFS_W-1:0]  ofs,
    output logic              lo_nib
);
    logic [IDX_W-1:0] bank_idx;
    logic [X_W-2:0]   col;

    assign col = pos.x[X_W-1:1];

    always_comb begin
        case (mode)
            MODE_320X256: begin
                bank_idx = pos.x[SPAN_BITS+IDX_W-1:SPAN_BITS];
                ofs      = {pos.x[SPAN_BITS-1:0], pos.y[BYTE_BITS-1:0]};
                lo_nib   = 1'b0;
            end
            MODE_640X256: begin
                bank_idx = col[SPAN_BITS+IDX_W-1:SPAN_BITS];
                ofs      = {col[SPAN_BITS-1:0], pos.y[BYTE_BITS-1:0]};
                lo_nib   = pos.x[0];
            end
            default: begin
                bank_idx = {1'b0, pos.y[BYTE_BITS-1:SPAN_BITS]};
                ofs      = {pos.y[SPAN_BITS-1:0], pos.x[BYTE_BITS-1:0]};
                lo_nib   = 1'b0;
            end
        endcase
        bank = first_bank + BANK_W'(bank_idx);
    end
endmodule

// File: rtl/bf_pix_format.sv
module bf_pix_format
    import bf_pkg::*;
(
    input  logic [PIX_W-1:0] data,
    input  logic             packed4,
    input  logic             lo_nib,
    input  logic [PAL_W-1:0] pal,
    output logic [PIX_W-1:0] index
);
    logic [NIB_W-1:0] hi, lo, sel;

    assign hi  = data[PIX_W-1:NIB_W];
    assign lo  = data[NIB_W-1:0];
    assign sel = lo_nib ? lo : hi;

    always_comb begin
        if (packed4) index = {pal, sel};
        else         index = {hi + pal, lo};
    end
endmodule

// File: rtl/bitmap_fetch.sv
module bitmap_fetch
    import bf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              beam_vld,
    input  logic [X_W-1:0]    beam_x,
    input  logic [Y_W-1:0]    beam_y,
    input  logic [1:0]        mode,
    input  logic [BANK_W-1:0] first_bank,
    input  logic [X_W-1:0]    scroll_x,
    input  logic [Y_W-1:0]    scroll_y,
    input  logic [PAL_W-1:0]  pal_ofs,
    output logic              addr_vld,
    output logic [BANK_W-1:0] addr_bank,
    output logic [OFS_W-1:0]  addr_ofs,
    input  logic [PIX_W-1:0]  mem_data,
    output logic              pix_vld,
    output logic [PIX_W-1:0]  pix_index
);
    lay_mode_e         md;
    coord_t            beam, shift, pos;
    logic [BANK_W-1:0] bank_c;
    logic [OFS_W-1:0]  ofs_c;
    logic              lo_c;
    logic [PIX_W-1:0]  idx_c;

    fetch_t            st1_q;
    logic              vld1_q, vld2_q;
    logic [PIX_W-1:0]  idx_q;

    assign md    = to_mode(mode);
    assign beam  = '{x: beam_x, y: beam_y};
    assign shift = '{x: scroll_x, y: scroll_y};

    bf_scroll_wrap u_wrap (
        .mode  (md),
        .beam  (beam),
        .shift (shift),
        .pos   (pos)
    );

    bf_addr_map u_map (
        .mode       (md),
        .pos        (pos),
        .first_bank (first_bank),
        .bank       (bank_c),
        .ofs        (ofs_c),
        .lo_nib     (lo_c)
    );

    bf_pix_format u_fmt (
        .data    (mem_data),
        .packed4 (st1_q.packed4),
        .lo_nib  (st1_q.lo_nib),
        .pal     (st1_q.pal),
        .index   (idx_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st1_q  <= '0;
            vld1_q <= 1'b0;
            vld2_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            vld1_q <= beam_vld;
            vld2_q <= vld1_q;
            if (beam_vld) begin
                st1_q.bank    <= bank_c;
                st1_q.ofs     <= ofs_c;
                st1_q.lo_nib  <= lo_c;
                st1_q.packed4 <= (md == MODE_640X256);
                st1_q.pal     <= pal_ofs;
            end
            if (vld1_q) idx_q <= idx_c;
        end
    end

    assign addr_vld  = vld1_q;
    assign addr_bank = st1_q.bank;
    assign addr_ofs  = st1_q.ofs;
    assign pix_vld   = vld2_q;
    assign pix_index = idx_q;
endmodule

// File: rtl/bf_checker.sv
module bf_checker
    import bf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              beam_vld,
    input logic [1:0]        mode,
    input logic [BANK_W-1:0] first_bank,
    input logic [PAL_W-1:0]  pal_ofs,
    input logic              addr_vld,
    input logic [BANK_W-1:0] addr_bank,
    input logic              pix_vld,
    input logic [PIX_W-1:0]  pix_index
);
    // R1: reset clears both valid stages
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!addr_vld && !pix_vld));

    // R2: address stage follows the request by one cycle
    a_r2_addr_follows: assert property (@(posedge clk) disable iff (rst)
        beam_vld |=> addr_vld);

    a_r2_addr_quiet: assert property (@(posedge clk) disable iff (rst)
        !beam_vld |=> !addr_vld);

    // R2: pixel stage follows the address stage by one cycle
    a_r2_pix_follows: assert property (@(posedge clk) disable iff (rst)
        addr_vld |=> pix_vld);

    // R3 / R10: 256x192 image spans three banks from the first bank
    a_r3_bank_span: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && ($past(mode) == 2'd0 || $past(mode) == 2'd3))
        |-> (BANK_W'(addr_bank - $past(first_bank)) < BANK_W'(3)));

    // R4 / R5: column-ordered images span five banks
    a_r4_bank_span: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && ($past(mode) == 2'd1 || $past(mode) == 2'd2))
        |-> (BANK_W'(addr_bank - $past(first_bank)) < BANK_W'(5)));

    // R8: packed mode places the palette offset in the upper nibble
    a_r8_packed_upper: assert property (@(posedge clk) disable iff (rst)
        (pix_vld && $past(mode, 2) == 2'd2)
        |-> (pix_index[PIX_W-1:NIB_W] == $past(pal_ofs, 2)));
endmodule

bind bitmap_fetch bf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .beam_vld   (beam_vld),
    .mode       (mode),
    .first_bank (first_bank),
    .pal_ofs    (pal_ofs),
    .addr_vld   (addr_vld),
    .addr_bank  (addr_bank),
    .pix_vld    (pix_vld),
    .pix_index  (pix_index)
);

// File: tb/sim_bitmap_fetch.sv
`timescale 1ns/1ps
module sim_bitmap_fetch;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       beam_vld = 1'b0;
    logic [9:0] beam_x = '0;
    logic [8:0] beam_y = '0;
    logic [1:0] mode = '0;
    logic [7:0] first_bank = '0;
    logic [9:0] scroll_x = '0;
    logic [8:0] scroll_y = '0;
    logic [3:0] pal_ofs = '0;
    logic       addr_vld;
    logic [7:0] addr_bank;
    logic [13:0] addr_ofs;
    logic [7:0] mem_data;
    logic       pix_vld;
    logic [7:0] pix_index;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    bitmap_fetch u0 (
        .clk(clk), .rst(rst), .beam_vld(beam_vld), .beam_x(beam_x),
        .beam_y(beam_y), .mode(mode), .first_bank(first_bank),
        .scroll_x(scroll_x), .scroll_y(scroll_y), .pal_ofs(pal_ofs),
        .addr_vld(addr_vld), .addr_bank(addr_bank), .addr_ofs(addr_ofs),
        .mem_data(mem_data), .pix_vld(pix_vld), .pix_index(pix_index)
    );

    function automatic int memf(input int bank, input int ofs);
        return (bank * 37 + ofs * 5 + (ofs >> 7)) % 256;
    endfunction

    // Memory model: byte depends on both bank and offset
    always_comb mem_data = 8'(memf(int'(addr_bank), int'(addr_ofs)));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic one_pix(input int m, input int fb, input int bx, input int by,
                           input int sx, input int sy, input int pal,
                           input string atag, input string itag);
        int mm, w, h, ex, ey, col, idx, ofs, lo, bank, d, eidx;
        mm = (m == 3) ? 0 : m;
        w = (mm == 2) ? 640 : (mm == 1) ? 320 : 256;
        h = (mm == 0) ? 192 : 256;
        ex = (bx + sx) % w;
        ey = (by + sy) % h;
        lo = 0;
        if (mm == 0) begin
            idx = ey / 64; ofs = (ey % 64) * 256 + ex;
        end else if (mm == 1) begin
            idx = ex / 64; ofs = (ex % 64) * 256 + ey;
        end else begin
            col = ex / 2; idx = col / 64; ofs = (col % 64) * 256 + ey; lo = ex % 2;
        end
        bank = (fb + idx) % 256;
        d = memf(bank, ofs);
        if (mm == 2) eidx = pal * 16 + (lo != 0 ? d % 16 : d / 16);
        else         eidx = ((d / 16 + pal) % 16) * 16 + d % 16;

        @(negedge clk);
        mode = 2'(m); first_bank = 8'(fb); beam_x = 10'(bx); beam_y = 9'(by);
        scroll_x = 10'(sx); scroll_y = 9'(sy); pal_ofs = 4'(pal); beam_vld = 1'b1;
        @(negedge clk);
        check("R2 addr_vld", int'(addr_vld), 1);
        check({atag, " bank"}, int'(addr_bank), bank);
        check({atag, " ofs"}, int'(addr_ofs), ofs);
        beam_vld = 1'b0;
        @(negedge clk);
        check("R2 addr_vld drop", int'(addr_vld), 0);
        check("R2 pix_vld", int'(pix_vld), 1);
        check({itag, " index"}, int'(pix_index), eidx);
    endtask

    task automatic sweep(input int m, input int fb, input int sx, input int sy,
                         input int pal, input string atag, input string itag);
        int mm, w, h;
        mm = (m == 3) ? 0 : m;
        w = (mm == 2) ? 640 : (mm == 1) ? 320 : 256;
        h = (mm == 0) ? 192 : 256;
        for (int x = 0; x < w; x++) begin
            one_pix(m, fb, x, 0, sx, sy, pal, atag, itag);
            one_pix(m, fb, x, h - 1, sx, sy, pal, atag, itag);
        end
        for (int y = 0; y < h; y++) begin
            one_pix(m, fb, 0, y, sx, sy, pal, atag, itag);
            one_pix(m, fb, w - 1, y, sx, sy, pal, atag, itag);
            one_pix(m, fb, 65, y, sx, sy, pal, atag, itag);
        end
    endtask

    initial begin
        beam_vld = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 addr_vld in reset", int'(addr_vld), 0);
        check("R1 pix_vld in reset", int'(pix_vld), 0);
        @(negedge clk);
        beam_vld = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 addr_bank", int'(addr_bank), 0);
        check("R1 addr_ofs", int'(addr_ofs), 0);
        check("R1 pix_index", int'(pix_index), 0);
        check("R1 pix_vld", int'(pix_vld), 0);

        sweep(0, 9, 0, 0, 0, "R3", "R7");
        sweep(1, 18, 0, 0, 0, "R4", "R7");
        sweep(2, 18, 0, 0, 0, "R5", "R8");
        sweep(0, 9, 100, 150, 5, "R6", "R7");
        sweep(1, 30, 1023, 511, 15, "R6", "R7");
        sweep(2, 60, 700, 300, 9, "R6", "R8");
        sweep(1, 254, 0, 0, 3, "R9", "R7");
        sweep(2, 253, 17, 0, 12, "R9", "R8");
        sweep(3, 40, 3, 7, 6, "R10", "R10");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule